// File: doc/BRIEF.md
# Supply and Fault Restart Supervisor

This block is the digital core of the supply supervisor in a primary-side flyback controller. Comparators outside the block turn the supply and mains voltages into single-bit flags. The block receives those flags together with two kinds of fault request. From them it decides three things: whether the power switch may run, whether the high-voltage start-up current source charges the supply capacitor, and whether the 5 V auxiliary rail is powered.

There are two classes of fault, and they recover differently.

- **Auto-retry faults** (excess on-time, shorted winding, open control pin) stop switching. Switching comes back on its own after the supply capacitor has been discharged to the undervoltage level and recharged to the start-up level.
- **Latching faults** (lock input, confirmed overvoltage, over-temperature) also stop switching at once. The supply keeps cycling between the undervoltage and start-up levels, but switching does not resume. The only exit is the supply dropping below a much lower reset level, which in practice means mains was removed.

The block is one state register plus a charge-phase bit. Every output is decoded from those registers, so no input reaches an output in the same cycle. Flags are sampled on the rising clock edge with a synchronous active-high reset.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters OFF (state code 0). In OFF, `sw_en_o` = 0, `startup_src_en_o` = 1 and `aux_rail_en_o` = 0.
- R2: `state_o` reports the state as OFF = 0, CHARGING = 1, RUN = 2, RESTART = 3, LATCHED = 4. The state and all outputs change only at the clock edge that samples the causing inputs.
- R3: OFF moves to CHARGING at the first edge where `vcc_lt_reset_i` is low. CHARGING moves to RUN only at an edge where `vcc_ge_start_i` and `mains_ok_i` are both high; either flag alone keeps it in CHARGING.
- R4: In RUN, `sw_en_o` = 1 and `startup_src_en_o` = 0. In every other state, `sw_en_o` = 0.
- R5: In RUN, `vcc_lt_uvlo_i` high or `fault_retry_i` high moves the block to RESTART at that edge. `fault_retry_i` has no effect in the other states.
- R6: In RESTART and LATCHED, the start-up source runs in a charge phase:
  - it switches on at an edge with `vcc_lt_uvlo_i` high;
  - it switches off at an edge with `vcc_ge_start_i` high;
  - on entry it keeps its previous setting (on when coming from OFF or CHARGING, off when coming from RUN).
  
  RESTART returns to RUN only at an edge where the charge phase is on and both `vcc_ge_start_i` and `mains_ok_i` are high. A retry fault taken while the supply is high therefore waits for one full discharge-and-recharge cycle.
- R7: `fault_latch_i` high moves the block to LATCHED from any state unless `vcc_lt_reset_i` is high. This takes priority over a retry fault or an undervoltage in the same cycle.
- R8: LATCHED never re-enables switching and ignores start-up crossings and mains. Its only exit is `vcc_lt_reset_i`.
- R9: `vcc_lt_reset_i` high moves the block to OFF from any state, with priority over every other input.
- R10: `aux_rail_en_o` is 1 exactly in RUN and RESTART, and 0 in OFF, CHARGING and LATCHED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ge_start_i | input | 1 | Supply at or above the start-up level |
| vcc_lt_uvlo_i | input | 1 | Supply below the undervoltage lockout level |
| vcc_lt_reset_i | input | 1 | Supply below the latch-reset level |
| mains_ok_i | input | 1 | Mains above the operation-enabling level |
| fault_retry_i | input | 1 | Request for a safe (auto-retry) restart |
| fault_latch_i | input | 1 | Request for latched shutdown |
| sw_en_o | output | 1 | Power switch may operate |
| startup_src_en_o | output | 1 | High-voltage start-up current source enabled |
| aux_rail_en_o | output | 1 | 5 V auxiliary rail enabled |
| state_o | output | 3 | Current state code |

## Verification
Some properties are checked on every cycle by assertions:
- the reset level always wins;
- a latching request always lands in LATCHED, even when a retry fault or an undervoltage arrives alongside it;
- LATCHED holds until reset-level supply;
- every entry into RUN was preceded by both start and mains flags;
- an undervoltage in RUN always stops switching.

Other behaviour can only be shown by the bench's scenarios:
- the charge-phase sequencing inside RESTART and LATCHED, where the source stays off after a retry fault until the undervoltage edge;
- the refusal of a start-up crossing without mains;
- the repeated supply cycling in LATCHED that never restarts switching.

A behavioural model in the bench covers long pseudo-random flag sequences cycle by cycle.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_OFF      = 3'd0,
    ST_CHARGING = 3'd1,
    ST_RUN      = 3'd2,
    ST_RESTART  = 3'd3,
    ST_LATCHED  = 3'd4
  } supv_state_e;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_DEEP  = 2'd1,
    EV_LATCH = 2'd2,
    EV_STOP  = 2'd3
  } supv_evt_e;
endpackage

// File: rtl/supv_arb.sv
// Ranks the incoming requests into a single event for the state register.
module supv_arb
  import supv_pkg::*;
(
  input  supv_state_e state_i,
  input  logic        vcc_lt_reset_i,
  input  logic        vcc_lt_uvlo_i,
  input  logic        fault_retry_i,
  input  logic        fault_latch_i,
  output supv_evt_e   evt_o
);
  always_comb begin
    if (vcc_lt_reset_i)
      evt_o = EV_DEEP;
    else if (fault_latch_i)
      evt_o = EV_LATCH;
    else if (state_i == ST_RUN && (fault_retry_i || vcc_lt_uvlo_i))
      evt_o = EV_STOP;
    else
      evt_o = EV_NONE;
  end
endmodule

// File: rtl/supv_fsm.sv
// State register plus the charge-phase bit used in RESTART and LATCHED.
module supv_fsm
  import supv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  supv_evt_e   evt_i,
  input  logic        vcc_ge_start_i,
  input  logic        vcc_lt_uvlo_i,
  input  logic        vcc_lt_reset_i,
  input  logic        mains_ok_i,
  input  logic        fault_latch_i,
  output supv_state_e state_o,
  output logic        chg_o
);
  supv_state_e state_q, state_d;
  logic        chg_q, chg_d;
  logic        chg_carry, chg_upd;

  // Source setting inherited on entry, then moved by the supply crossings.
  always_comb begin
    unique case (state_q)
      ST_OFF, ST_CHARGING: chg_carry = 1'b1;
      ST_RUN:              chg_carry = 1'b0;
      default:             chg_carry = chg_q;
    endcase
    if (vcc_lt_uvlo_i)       chg_upd = 1'b1;
    else if (vcc_ge_start_i) chg_upd = 1'b0;
    else                     chg_upd = chg_carry;
  end

  always_comb begin
    state_d = state_q;
    chg_d   = chg_q;
    unique case (evt_i)
      EV_DEEP:  begin state_d = ST_OFF;     chg_d = 1'b0;    end
      EV_LATCH: begin state_d = ST_LATCHED; chg_d = chg_upd; end
      EV_STOP:  begin state_d = ST_RESTART; chg_d = chg_upd; end
      default: begin
        unique case (state_q)
          ST_OFF: state_d = ST_CHARGING;
          ST_CHARGING:
            if (vcc_ge_start_i && mains_ok_i) state_d = ST_RUN;
          ST_RESTART:
            if (chg_q && vcc_ge_start_i && mains_ok_i) begin
              state_d = ST_RUN;
              chg_d   = 1'b0;
            end else begin
              chg_d = chg_upd;
            end
          ST_LATCHED: chg_d = chg_upd;
          default: ;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      chg_q   <= chg_d;
    end
  end

  assign state_o = state_q;
  assign chg_o   = chg_q;

  assert_deep_wins_R9: assert property (@(posedge clk) disable iff (rst)
    vcc_lt_reset_i |=> state_q == ST_OFF);

  assert_latch_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (fault_latch_i && !vcc_lt_reset_i) |=> state_q == ST_LATCHED);

  assert_latched_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LATCHED && !vcc_lt_reset_i) |=> state_q == ST_LATCHED);

  assert_run_needs_start_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) != ST_RUN)
      |-> $past(vcc_ge_start_i && mains_ok_i));

  assert_uvlo_stops_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && vcc_lt_uvlo_i && !fault_latch_i && !vcc_lt_reset_i)
      |=> state_q == ST_RESTART);
endmodule

// File: rtl/supv_outdec.sv
// Output decode from the registered state; no input-to-output path.
module supv_outdec
  import supv_pkg::*;
(
  input  supv_state_e state_i,
  input  logic        chg_i,
  output logic        sw_en_o,
  output logic        src_en_o,
  output logic        aux_en_o
);
  always_comb begin
    sw_en_o  = (state_i == ST_RUN);
    aux_en_o = (state_i == ST_RUN) || (state_i == ST_RESTART);
    unique case (state_i)
      ST_OFF, ST_CHARGING:    src_en_o = 1'b1;
      ST_RESTART, ST_LATCHED: src_en_o = chg_i;
      default:                src_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               vcc_ge_start_i,
  input  logic               vcc_lt_uvlo_i,
  input  logic               vcc_lt_reset_i,
  input  logic               mains_ok_i,
  input  logic               fault_retry_i,
  input  logic               fault_latch_i,
  output logic               sw_en_o,
  output logic               startup_src_en_o,
  output logic               aux_rail_en_o,
  output logic [STATE_W-1:0] state_o
);
  supv_state_e state;
  supv_evt_e   evt;
  logic        chg;

  supv_arb u_arb (
    .state_i        (state),
    .vcc_lt_reset_i (vcc_lt_reset_i),
    .vcc_lt_uvlo_i  (vcc_lt_uvlo_i),
    .fault_retry_i  (fault_retry_i),
    .fault_latch_i  (fault_latch_i),
    .evt_o          (evt)
  );

  supv_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .evt_i          (evt),
    .vcc_ge_start_i (vcc_ge_start_i),
    .vcc_lt_uvlo_i  (vcc_lt_uvlo_i),
    .vcc_lt_reset_i (vcc_lt_reset_i),
    .mains_ok_i     (mains_ok_i),
    .fault_latch_i  (fault_latch_i),
    .state_o        (state),
    .chg_o          (chg)
  );

  supv_outdec u_dec (
    .state_i  (state),
    .chg_i    (chg),
    .sw_en_o  (sw_en_o),
    .src_en_o (startup_src_en_o),
    .aux_en_o (aux_rail_en_o)
  );

  assign state_o = state;

  assert_sw_src_excl_R4: assert property (@(posedge clk) disable iff (rst)
    sw_en_o |-> !startup_src_en_o);

  assert_aux_off_latched_R10: assert property (@(posedge clk) disable iff (rst)
    $past(fault_latch_i && !vcc_lt_reset_i) |-> !aux_rail_en_o && !sw_en_o);
endmodule

// File: tb/supply_supervisor_tb_top.sv
module supply_supervisor_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic v_start = 1'b0, v_uvlo = 1'b0, v_reset = 1'b0, mains = 1'b0;
  logic f_retry = 1'b0, f_latch = 1'b0;
  logic sw, src, aux;
  logic [2:0] st;
  int tests = 0, fails = 0;
  bit compare_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  supply_supervisor dut_i (
    .clk(clk), .rst(rst),
    .vcc_ge_start_i(v_start), .vcc_lt_uvlo_i(v_uvlo), .vcc_lt_reset_i(v_reset),
    .mains_ok_i(mains), .fault_retry_i(f_retry), .fault_latch_i(f_latch),
    .sw_en_o(sw), .startup_src_en_o(src), .aux_rail_en_o(aux), .state_o(st)
  );

  // Behavioural reference: 0 off,1 charging,2 run,3 restart,4 latched
  int m_st = 0;
  bit m_src_phase = 1'b0;

  always @(posedge clk) begin
    int n_st;
    bit inherit, moved;
    n_st = m_st;
    inherit = (m_st <= 1) ? 1'b1 : (m_st == 2) ? 1'b0 : m_src_phase;
    moved = v_uvlo ? 1'b1 : (v_start ? 1'b0 : inherit);
    if (rst) begin
      m_st <= 0; m_src_phase <= 1'b0;
    end else if (v_reset) begin
      m_st <= 0; m_src_phase <= 1'b0;
    end else if (f_latch) begin
      m_st <= 4; m_src_phase <= moved;
    end else begin
      case (m_st)
        0: n_st = 1;
        1: if (v_start && mains) n_st = 2;
        2: if (f_retry || v_uvlo) begin n_st = 3; m_src_phase <= moved; end
        3: if (m_src_phase && v_start && mains) begin n_st = 2; m_src_phase <= 1'b0; end
           else m_src_phase <= moved;
        default: m_src_phase <= moved;
      endcase
      m_st <= n_st;
    end
  end

  function automatic bit exp_src();
    return (m_st <= 1) || ((m_st == 3 || m_st == 4) && m_src_phase);
  endfunction

  always @(negedge clk) begin
    if (compare_on) begin
      tests++;
      if (st !== 3'(m_st)) begin fails++; $display("FAIL R2 state act=%0d exp=%0d", st, m_st); end
      else if (sw !== (m_st == 2)) begin fails++; $display("FAIL R4 sw act=%0b exp=%0b", sw, m_st == 2); end
      else if (src !== exp_src()) begin fails++; $display("FAIL R6 src act=%0b exp=%0b", src, exp_src()); end
      else if (aux !== (m_st == 2 || m_st == 3)) begin
        fails++; $display("FAIL R10 aux act=%0b exp=%0b", aux, m_st == 2 || m_st == 3);
      end
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] es, logic esw, logic esrc, logic eaux);
    tests++;
    if (st !== es || sw !== esw || src !== esrc || aux !== eaux) begin
      fails++;
      $display("FAIL %s act st=%0d sw=%0b src=%0b aux=%0b exp st=%0d sw=%0b src=%0b aux=%0b",
               req, st, sw, src, aux, es, esw, esrc, eaux);
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    @(negedge clk); tick();
    chk("R1", 3'd0, 0, 1, 0);
    compare_on = 1'b1;
    rst = 1'b0; v_reset = 1'b1; tick();
    chk("R9", 3'd0, 0, 1, 0);
    v_reset = 1'b0; tick();
    chk("R3", 3'd1, 0, 1, 0);
    v_start = 1'b1; tick();
    chk("R3", 3'd1, 0, 1, 0);          // no mains: stay charging
    mains = 1'b1; tick();
    chk("R4", 3'd2, 1, 0, 1);
    v_start = 1'b0; v_uvlo = 1'b1; tick();
    chk("R5", 3'd3, 0, 1, 1);
    v_uvlo = 1'b0; tick(); tick();
    chk("R6", 3'd3, 0, 1, 1);
    v_start = 1'b1; tick();
    chk("R6", 3'd2, 1, 0, 1);
    f_retry = 1'b1; tick(); f_retry = 1'b0;
    chk("R5", 3'd3, 0, 0, 1);
    tick();
    chk("R6", 3'd3, 0, 0, 1);          // start crossing without discharge ignored
    v_start = 1'b0; v_uvlo = 1'b1; tick();
    chk("R6", 3'd3, 0, 1, 1);
    v_uvlo = 1'b0; v_start = 1'b1; tick();
    chk("R6", 3'd2, 1, 0, 1);
    f_latch = 1'b1; f_retry = 1'b1; tick(); f_latch = 1'b0; f_retry = 1'b0;
    chk("R7", 3'd4, 0, 0, 0);
    v_start = 1'b0; v_uvlo = 1'b1; tick();
    chk("R8", 3'd4, 0, 1, 0);
    v_uvlo = 1'b0; v_start = 1'b1; tick(); tick();
    chk("R8", 3'd4, 0, 0, 0);
    v_start = 1'b0; v_reset = 1'b1; tick();
    chk("R9", 3'd0, 0, 1, 0);
    v_reset = 1'b0; tick();
    chk("R3", 3'd1, 0, 1, 0);
    f_retry = 1'b1; tick(); f_retry = 1'b0;
    chk("R5", 3'd1, 0, 1, 0);          // retry ignored outside run
    f_latch = 1'b1; tick(); f_latch = 1'b0;
    chk("R7", 3'd4, 0, 1, 0);
    f_latch = 1'b1; v_reset = 1'b1; tick(); f_latch = 1'b0; v_reset = 1'b0;
    chk("R9", 3'd0, 0, 1, 0);
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v_start = lfsr[0] & lfsr[1];
      v_uvlo  = ~v_start & lfsr[2] & lfsr[3];
      v_reset = (lfsr[15:9] == 7'd5);
      mains   = lfsr[4] | lfsr[5];
      f_retry = (lfsr[8:6] == 3'd7);
      f_latch = (lfsr[14:9] == 6'd11);
      tick();
    end
    compare_on = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule